// File: doc/BRIEF.md
# Channel Code to Synthesizer Divide-Ratio Converter

This block turns the 6-bit code from a channel selector, together with a transmit/receive mode line, into the 10-bit divide ratio N that a frequency synthesizer loads into its programmable divider. With a 5 kHz comparison frequency and a fixed 15.360 MHz offset, the oscillator runs at 15 360 kHz + 5·N kHz. Each step of N is therefore 5 kHz, and one 10 kHz channel slot is two steps of N. The block holds a single table of transmit ratios. In receive mode it subtracts a fixed offset of 91. That offset moves the oscillator down by 455 kHz, which is the intermediate frequency, so one table serves both modes.

A selector switch that is moving between detents presents codes that mean nothing. The block accepts a code only after it has held the same value at two consecutive clock edges. An accepted code that is not one of the 40 channels drops the valid flag. In that case the ratio output keeps its last good value, so the divider is never loaded with a ratio that has no meaning.

Control is a three-state machine. ST_EMPTY is the state after reset, before any channel has been accepted. ST_TRACK means the accepted code is a channel and N follows it. ST_BAD means the accepted code is not a channel and N is frozen. There are three transitions, and each can be taken from any state. SETTLE-HOLD: the code differs from its previous sample, so the state and the outputs stay as they are. ACCEPT-GOOD: the code is stable and is a channel, so the machine goes to ST_TRACK and N and the flag are loaded. ACCEPT-BAD: the code is stable and is not a channel, so the machine goes to ST_BAD, the flag clears and N holds.

Top module: `chan_divratio`

## Requirements
- R1: During and after an active-low reset, and until a code is accepted, `code_ok_o` is 0 and `div_n_o` is 0.
- R2: The code is the channel number in plain binary. Values 1 to 40 are channels. Value 0 and values 41 to 63 are not channels, and accepting one of them forces `code_ok_o` to 0.
- R3: In transmit mode (`rx_mode_i` = 0), channel c gives N = 273 + 2·s. The slot index s counts 10 kHz slots from channel 1. One unused slot follows each of channels 3, 7, 11, 15 and 19, so s = c−1+min(5, c div 4). Channel 1 gives 273, channel 4 gives 281, channel 23 gives 327 and channel 40 gives 361. All 40 values are strictly increasing.
- R4: In receive mode (`rx_mode_i` = 1), N is the transmit value minus 91. Channel 1 gives 182 and channel 40 gives 270.
- R5: A new code is accepted only at the second consecutive rising edge at which it is present. The outputs therefore change after that second edge, and never after the first.
- R6: While the accepted code is not a channel, `div_n_o` keeps the last value loaded for a valid channel. The value is 0 if no channel has been accepted since reset.
- R7: When the code stays steady and only `rx_mode_i` changes, N follows after the next rising edge.
- R8: A code that lasts a single clock and then returns to the previous value leaves both outputs unchanged.
- R9: Whenever `code_ok_o` is 1, `div_n_o` lies in the transmit band 273–361 or in the receive band 182–270.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_code_i | input | 6 | Channel code from the selector (binary channel number) |
| rx_mode_i | input | 1 | 1 = receive, 0 = transmit |
| div_n_o | output | 10 | Registered divide ratio N |
| code_ok_o | output | 1 | Registered flag: the accepted code is a channel |

## Verification
On every cycle the checker enforces four things. N stays within the two bands while the flag is high. N is frozen while the flag is low. An output may change only after a code that was identical at the two preceding edges. An accepted non-channel code clears the flag, and an accepted channel code lands in the band that matches the sampled mode. The exact ratio of each channel cannot be shown by a property: the gap positions, the end points 273 and 361, and the 91 receive offset come only from the bench's sweep of all 64 codes in both modes against its reference model. The same applies to the two-edge acceptance latency, counted edge by edge, and to the one-clock glitch being rejected.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int CC_CODE_W   = 6;
    localparam int CC_N_W      = 10;
    localparam int CC_TX_FIRST = 273;
    localparam int CC_TX_LAST  = 361;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_TRACK = 2'd1,
        ST_BAD   = 2'd2
    } cc_state_e;

    // Transmit divide ratio per channel number; 0 for non-channels.
    function automatic logic [CC_N_W-1:0] cc_tx_ratio(input logic [CC_CODE_W-1:0] ch);
        logic [CC_N_W-1:0] r;
        unique case (ch)
            6'd1:  r = 10'd273;
            6'd2:  r = 10'd275;
            6'd3:  r = 10'd277;
            6'd4:  r = 10'd281;
            6'd5:  r = 10'd283;
            6'd6:  r = 10'd285;
            6'd7:  r = 10'd287;
            6'd8:  r = 10'd291;
            6'd9:  r = 10'd293;
            6'd10: r = 10'd295;
            6'd11: r = 10'd297;
            6'd12: r = 10'd301;
            6'd13: r = 10'd303;
            6'd14: r = 10'd305;
            6'd15: r = 10'd307;
            6'd16: r = 10'd311;
            6'd17: r = 10'd313;
            6'd18: r = 10'd315;
            6'd19: r = 10'd317;
            6'd20: r = 10'd321;
            6'd21: r = 10'd323;
            6'd22: r = 10'd325;
            6'd23: r = 10'd327;
            6'd24: r = 10'd329;
            6'd25: r = 10'd331;
            6'd26: r = 10'd333;
            6'd27: r = 10'd335;
            6'd28: r = 10'd337;
            6'd29: r = 10'd339;
            6'd30: r = 10'd341;
            6'd31: r = 10'd343;
            6'd32: r = 10'd345;
            6'd33: r = 10'd347;
            6'd34: r = 10'd349;
            6'd35: r = 10'd351;
            6'd36: r = 10'd353;
            6'd37: r = 10'd355;
            6'd38: r = 10'd357;
            6'd39: r = 10'd359;
            6'd40: r = 10'd361;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cc_code_filter.sv
module cc_code_filter #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    output logic              stable_o
);
    logic [CODE_W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= code_i;
        end
    end

    assign stable_o = (code_i == prev_q);
endmodule

// File: rtl/cc_ratio_rom.sv
module cc_ratio_rom
    import cc_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int N_W       = 10,
    parameter int LAST_CH   = 40,
    parameter int RX_OFFSET = 91
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              rx_i,
    output logic [N_W-1:0]    n_o,
    output logic              hit_o
);
    localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(LAST_CH);
    localparam logic [N_W-1:0]    RX_SUB    = N_W'(RX_OFFSET);

    logic [N_W-1:0] tx_n;

    always_comb begin
        tx_n  = N_W'(cc_tx_ratio(CC_CODE_W'(code_i)));
        hit_o = (code_i != '0) && (code_i <= LAST_CODE);
        n_o   = rx_i ? (tx_n - RX_SUB) : tx_n;
    end
endmodule

// File: rtl/chan_divratio.sv
module chan_divratio
    import cc_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int N_W       = 10,
    parameter int LAST_CH   = 40,
    parameter int RX_OFFSET = 91
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] chan_code_i,
    input  logic              rx_mode_i,
    output logic [N_W-1:0]    div_n_o,
    output logic              code_ok_o
);
    cc_state_e      state_q, state_d;
    logic           stable;
    logic           hit;
    logic [N_W-1:0] lut_n;
    logic [N_W-1:0] n_q;
    logic           ok_q;

    cc_code_filter #(.CODE_W(CODE_W)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_i   (chan_code_i),
        .stable_o (stable)
    );

    cc_ratio_rom #(
        .CODE_W    (CODE_W),
        .N_W       (N_W),
        .LAST_CH   (LAST_CH),
        .RX_OFFSET (RX_OFFSET)
    ) u_rom (
        .code_i (chan_code_i),
        .rx_i   (rx_mode_i),
        .n_o    (lut_n),
        .hit_o  (hit)
    );

    // Next state: SETTLE-HOLD, ACCEPT-GOOD, ACCEPT-BAD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY, ST_TRACK, ST_BAD: begin
                if (!stable)   state_d = state_q;
                else if (hit)  state_d = ST_TRACK;
                else           state_d = ST_BAD;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q  <= '0;
            ok_q <= 1'b0;
        end else begin
            if (stable && hit) n_q <= lut_n;
            ok_q <= (state_d == ST_TRACK);
        end
    end

    assign div_n_o   = n_q;
    assign code_ok_o = ok_q;
endmodule

// File: rtl/cc_chk.sv
module cc_chk #(
    parameter int CODE_W    = 6,
    parameter int N_W       = 10,
    parameter int LAST_CH   = 40,
    parameter int RX_OFFSET = 91
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] chan_code_i,
    input logic              rx_mode_i,
    input logic [N_W-1:0]    div_n_o,
    input logic              code_ok_o
);
    localparam logic [N_W-1:0] TX_LO = N_W'(cc_pkg::CC_TX_FIRST);
    localparam logic [N_W-1:0] TX_HI = N_W'(cc_pkg::CC_TX_LAST);
    localparam logic [N_W-1:0] RX_LO = N_W'(cc_pkg::CC_TX_FIRST - RX_OFFSET);
    localparam logic [N_W-1:0] RX_HI = N_W'(cc_pkg::CC_TX_LAST - RX_OFFSET);
    localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(LAST_CH);

    assert_n_in_band_R9: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok_o |-> ((div_n_o >= TX_LO && div_n_o <= TX_HI) ||
                       (div_n_o >= RX_LO && div_n_o <= RX_HI)));

    assert_hold_when_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !code_ok_o |-> $stable(div_n_o));

    assert_two_edge_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(div_n_o) || !$stable(code_ok_o)) |->
            ($past(chan_code_i, 1) == $past(chan_code_i, 2)));

    assert_bad_code_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(chan_code_i, 1) == $past(chan_code_i, 2)) &&
         (($past(chan_code_i) == '0) || ($past(chan_code_i) > LAST_CODE)))
            |-> !code_ok_o);

    assert_tx_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_ok_o && ($past(chan_code_i, 1) == $past(chan_code_i, 2)) && !$past(rx_mode_i))
            |-> (div_n_o >= TX_LO && div_n_o <= TX_HI));

    assert_rx_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_ok_o && ($past(chan_code_i, 1) == $past(chan_code_i, 2)) && $past(rx_mode_i))
            |-> (div_n_o >= RX_LO && div_n_o <= RX_HI));
endmodule

bind chan_divratio cc_chk #(
    .CODE_W    (CODE_W),
    .N_W       (N_W),
    .LAST_CH   (LAST_CH),
    .RX_OFFSET (RX_OFFSET)
) u_cc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_code_i (chan_code_i),
    .rx_mode_i   (rx_mode_i),
    .div_n_o     (div_n_o),
    .code_ok_o   (code_ok_o)
);

// File: tb/tb_chan_divratio.sv
module tb_chan_divratio;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] code = '0;
    logic       rx = 1'b0;
    logic [9:0] div_n;
    logic       ok;

    int total = 0;
    int fails = 0;
    bit checking = 0;
    string phase = "R1";

    int m_prev = 0;
    int m_ok = 0;
    int m_n = 0;

    always #4 clk = ~clk;

    chan_divratio dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_code_i (code),
        .rx_mode_i   (rx),
        .div_n_o     (div_n),
        .code_ok_o   (ok)
    );

    // Reference: antenna frequency from channel slots, then VCO and N.
    function automatic int ref_n(int c, bit r);
        int slot = 0;
        int f_ant;
        int f_vco;
        if (c < 1 || c > 40) return -1;
        for (int ch = 2; ch <= c; ch++) begin
            slot += 1;
            if ((ch - 1) == 3 || (ch - 1) == 7 || (ch - 1) == 11 ||
                (ch - 1) == 15 || (ch - 1) == 19) slot += 1;
        end
        f_ant = 26965 + 10 * slot;
        f_vco = f_ant - 10240;
        if (r) f_vco -= 455;
        return (f_vco - 15360) / 5;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 0; m_ok = 0; m_n = 0;
        end else begin
            if (int'(code) == m_prev) begin
                if (ref_n(int'(code), rx) >= 0) begin
                    m_ok = 1;
                    m_n  = ref_n(int'(code), rx);
                end else begin
                    m_ok = 0;
                end
            end
            m_prev = int'(code);
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            total++;
            if (int'(ok) != m_ok || int'(div_n) != m_n) begin
                fails++;
                $display("FAIL %s model: got n=%0d ok=%0d expected n=%0d ok=%0d",
                         phase, div_n, ok, m_n, m_ok);
            end
        end
    end

    task automatic expect_out(input string req, input int en, input int eok);
        total++;
        if (int'(div_n) != en || int'(ok) != eok) begin
            fails++;
            $display("FAIL %s: got n=%0d ok=%0d expected n=%0d ok=%0d",
                     req, div_n, ok, en, eok);
        end
    endtask

    task automatic apply(input int c, input bit r, input int cyc);
        code = 6'(c);
        rx   = r;
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        total++;
        $display("FAIL watchdog: got hang expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 0, 0);
        rst_n = 1'b1;
        expect_out("R1 after release", 0, 0);
        checking = 1;
        phase = "R1";
        apply(0, 0, 3);
        expect_out("R1 no channel yet", 0, 0);
        phase = "R6";
        apply(50, 0, 3);
        expect_out("R6 no channel since reset", 0, 0);

        // Full sweep, both modes
        phase = "R2";
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 64; c++) apply(c, bit'(m), 3);
        end

        phase = "R3";
        apply(1, 0, 3);  expect_out("R3 ch1 tx", 273, 1);
        apply(3, 0, 3);  expect_out("R3 ch3 tx", 277, 1);
        apply(4, 0, 3);  expect_out("R3 ch4 tx gap", 281, 1);
        apply(23, 0, 3); expect_out("R3 ch23 tx", 327, 1);
        apply(40, 0, 3); expect_out("R3 ch40 tx", 361, 1);

        phase = "R4";
        apply(1, 1, 3);  expect_out("R4 ch1 rx", 182, 1);
        apply(40, 1, 3); expect_out("R4 ch40 rx", 270, 1);

        phase = "R2";
        apply(41, 1, 3); expect_out("R2 code 41 invalid", 270, 0);

        phase = "R5";
        apply(2, 0, 3);
        code = 6'd9;
        @(negedge clk); expect_out("R5 after first edge", 275, 1);
        @(negedge clk); expect_out("R5 after second edge", 293, 1);

        phase = "R8";
        apply(10, 0, 3);
        code = 6'd20;
        @(negedge clk); expect_out("R8 glitch edge", 295, 1);
        code = 6'd10;
        @(negedge clk); expect_out("R8 return edge", 295, 1);
        @(negedge clk); expect_out("R8 settled", 295, 1);

        phase = "R6";
        apply(5, 1, 3);  expect_out("R6 ch5 rx", 192, 1);
        apply(45, 1, 3); expect_out("R6 hold on 45", 192, 0);
        apply(0, 0, 3);  expect_out("R6 hold on 0", 192, 0);
        apply(63, 1, 3); expect_out("R6 hold on 63", 192, 0);

        phase = "R7";
        apply(30, 0, 3); expect_out("R7 ch30 tx", 341, 1);
        rx = 1'b1;
        @(negedge clk); expect_out("R7 mode to rx", 250, 1);
        rx = 1'b0;
        @(negedge clk); expect_out("R7 mode to tx", 341, 1);

        phase = "R9";
        for (int c = 1; c <= 40; c += 13) apply(c, bit'(c % 2), 3);

        checking = 0;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule